// File: doc/BRIEF.md
# Unscaled Halfword Load/Store Executor

This block executes one family of 32-bit load/store instruction words that move a single 16-bit halfword between a general register and memory. Each instruction names a transfer register, a base register (or the stack pointer) and a signed 9-bit byte offset. The block works out the effective address and issues exactly one two-byte memory request. A load's returned halfword is extended to a 32-bit or 64-bit destination and written back. Loads are tagged with acquire ordering and stores with release ordering. Every access asks for tag checking unless it is addressed through the stack pointer.

The unit handles one instruction at a time. It takes the instruction word and its operand values in a single accept handshake, then walks through decode, address generation, request issue, response wait and an optional writeback cycle. It stays busy until the response has been taken, so a later instruction cannot reach memory before an earlier acquire load has completed.

There are three valid/ready streams: instruction in, request out and response in. A producer that raises valid keeps the payload stable until the cycle in which ready is also high. The block holds every request field constant while `req_valid` is high and `req_ready` is low. `ins_ready` and `rsp_ready` are only asserted in states where the transfer will be taken. Writeback, busy and the two faults are plain strobes with no handshake.

Top module: `hw_ldst_unit`

## Requirements
- R1: `ins_ready` is high exactly when no instruction is in progress. After an accepted instruction, `busy` is high and `ins_ready` is low in the following cycle.
- R2: A word is legal only if bits 31:24 are 0x59, bit 21 is 0 and bits 11:10 are 00. Any other word raises `fault_undef` for one cycle and produces no request and no writeback.
- R3: Bits 23:22 select the operation: 00 store, 01 zero-extending load to 32 bits, 10 sign-extending load to 64 bits, 11 sign-extending load to 32 bits. For a 32-bit destination, bits 63:32 of `wb_data` are zero and `wb_is64` is 0.
- R4: `req_addr` is the base value plus the offset in bits 20:12, sign-extended to 64 bits. The base index is bits 9:5, and the register-file read index outputs mirror bits 9:5 and 4:0 of `ins_word`.
- R5: A base index of 31 uses `sp_value` instead of `rd_base_data`. If the low 4 bits of the stack pointer are not all zero, `fault_align` pulses for one cycle and no request is issued.
- R6: `req_tagchk` is 1 when the base index is not 31 and 0 when it is 31.
- R7: A store sends the low halfword of the transfer register (index in bits 4:0) with `req_write`=1. A transfer index of 31 sends zero. `req_nbytes` is always 2.
- R8: A load request has `req_acquire`=1 and `req_release`=0. A store request has `req_release`=1 and `req_acquire`=0.
- R9: While `req_valid` is high and `req_ready` is low, the request stays asserted with unchanged address, data and direction.
- R10: Exactly one request is issued per legal instruction. `busy` stays high, and no new request appears, from acceptance until the response has been taken.
- R11: A load pulses `wb_valid` for one cycle with `wb_idx` equal to bits 4:0. A transfer index of 31 suppresses the pulse, and stores never pulse.
- R12: When `dit_en`=1 at acceptance, the cycle count from acceptance to `ins_ready` is the same for stores and loads, whatever the data and the transfer index. When `dit_en`=0, operations with no writeback skip the final cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| dit_en | input | 1 | Data-independent timing request, captured at acceptance |
| ins_valid | input | 1 | Instruction stream valid |
| ins_ready | output | 1 | Instruction stream ready |
| ins_word | input | 32 | Instruction word |
| rd_base_idx | output | 5 | Register-file read index for the base |
| rd_base_data | input | 64 | Base register value |
| rd_xfer_idx | output | 5 | Register-file read index for the transfer register |
| rd_xfer_data | input | 16 | Low halfword of the transfer register |
| sp_value | input | 64 | Stack pointer value |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory request ready |
| req_addr | output | 64 | Byte address |
| req_write | output | 1 | 1 for store, 0 for load |
| req_wdata | output | 16 | Store halfword |
| req_nbytes | output | 4 | Access size in bytes (always 2) |
| req_tagchk | output | 1 | Tag check requested |
| req_acquire | output | 1 | Acquire ordering mark |
| req_release | output | 1 | Release ordering mark |
| rsp_valid | input | 1 | Memory response valid |
| rsp_ready | output | 1 | Memory response ready |
| rsp_rdata | input | 16 | Loaded halfword |
| wb_valid | output | 1 | Register write strobe |
| wb_idx | output | 5 | Destination register index |
| wb_data | output | 64 | Value to write |
| wb_is64 | output | 1 | 1 when the destination is 64 bits wide |
| busy | output | 1 | Instruction in progress |
| fault_undef | output | 1 | Undefined encoding pulse |
| fault_align | output | 1 | Stack pointer misalignment pulse |

## Verification
The bench loads the halfword 0x8001 through all three load forms. A design that mixes up opcode bits 0 and 1 would sign-extend to the wrong width, or would leave ones in bits 63:32 of a 32-bit result. It drives the offset extremes -256 and +255, where an offset that is zero-extended or truncated gives a visibly wrong address. It also addresses through the stack pointer with garbage on the base-register input, which catches a base mux or tag-check flag that ignores index 31. It gives the stack pointer a low nibble of 8, which a design that checks too few bits, or issues the request anyway, would miss.

Index 31 as the transfer register exposes a store that leaks the register-file value and a load that still writes back. Stalled request and response handshakes expose a request that moves or drops early and a unit that frees itself before the response. Latency comparisons across data, operation and transfer index, with `dit_en` on and off, expose any cycle count that tracks the operands under data-independent timing.

// File: rtl/hw_ldst_pkg.sv
package hw_ldst_pkg;

  localparam int unsigned INS_W    = 32;
  localparam int unsigned RIDX_W   = 5;
  localparam int unsigned OFF_W    = 9;

  // Field positions in the instruction word
  localparam int unsigned MATCH_LSB = 24;
  localparam int unsigned OP_LSB    = 22;
  localparam int unsigned RSV_BIT   = 21;
  localparam int unsigned OFF_LSB   = 12;
  localparam int unsigned GAP_LSB   = 10;
  localparam int unsigned RN_LSB    = 5;
  localparam int unsigned RT_LSB    = 0;

  localparam logic [7:0] MATCH_VAL = 8'h59;

  typedef enum logic [1:0] {
    OP_ST     = 2'b00,
    OP_LDZ_W  = 2'b01,
    OP_LDS_X  = 2'b10,
    OP_LDS_W  = 2'b11
  } ldst_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DEC,
    S_AGEN,
    S_ISSUE,
    S_WAIT,
    S_WB
  } ldst_state_e;

  typedef struct packed {
    logic              legal;
    ldst_op_e          op;
    logic [OFF_W-1:0]  off;
    logic [RIDX_W-1:0] rn;
    logic [RIDX_W-1:0] rt;
  } ldst_dec_t;

  function automatic logic op_is_load(ldst_op_e op);
    return op[1] | op[0];
  endfunction

endpackage

// File: rtl/hw_ldst_decode.sv
module hw_ldst_decode
  import hw_ldst_pkg::*;
(
  input  logic [INS_W-1:0] ins,
  output ldst_dec_t        dec
);

  always_comb begin
    dec.legal = (ins[MATCH_LSB +: 8] == MATCH_VAL) &&
                !ins[RSV_BIT] &&
                (ins[GAP_LSB +: 2] == 2'b00);
    dec.op    = ldst_op_e'(ins[OP_LSB +: 2]);
    dec.off   = ins[OFF_LSB +: OFF_W];
    dec.rn    = ins[RN_LSB +: RIDX_W];
    dec.rt    = ins[RT_LSB +: RIDX_W];
  end

endmodule

// File: rtl/hw_ldst_agen.sv
module hw_ldst_agen #(
  parameter int unsigned AW         = 64,
  parameter int unsigned OW         = 9,
  parameter int unsigned ALIGN_BITS = 4,
  parameter int unsigned IW         = 5
) (
  input  logic [IW-1:0] base_idx,
  input  logic [AW-1:0] gpr_base,
  input  logic [AW-1:0] sp_base,
  input  logic [OW-1:0] off,
  output logic [AW-1:0] addr,
  output logic          use_sp,
  output logic          sp_misaligned,
  output logic          tag_check
);

  localparam logic [IW-1:0] SP_IDX = '1;

  logic [AW-1:0] base_sel;
  logic [AW-1:0] off_ext;

  always_comb begin
    use_sp    = (base_idx == SP_IDX);
    base_sel  = use_sp ? sp_base : gpr_base;
    off_ext   = {{(AW-OW){off[OW-1]}}, off};
    addr      = base_sel + off_ext;
    tag_check = !use_sp;
  end

  generate
    if (ALIGN_BITS == 0) begin : g_no_align
      assign sp_misaligned = 1'b0;
    end else begin : g_align
      assign sp_misaligned = use_sp && (|sp_base[ALIGN_BITS-1:0]);
    end
  endgenerate

endmodule

// File: rtl/hw_ldst_extend.sv
module hw_ldst_extend
  import hw_ldst_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  parameter int unsigned HW_W = 16
) (
  input  logic [HW_W-1:0] raw,
  input  ldst_op_e        op,
  output logic [XLEN-1:0] value,
  output logic            is64
);

  localparam int unsigned HALF = XLEN / 2;

  logic [XLEN-1:0] sx;

  always_comb begin
    sx   = {{(XLEN-HW_W){raw[HW_W-1]}}, raw};
    is64 = (op == OP_LDS_X);
    case (op)
      OP_LDS_X: value = sx;
      OP_LDS_W: value = {{HALF{1'b0}}, sx[HALF-1:0]};
      default:  value = {{(XLEN-HW_W){1'b0}}, raw};
    endcase
  end

endmodule

// File: rtl/hw_ldst_unit.sv
module hw_ldst_unit
  import hw_ldst_pkg::*;
#(
  parameter int unsigned XLEN          = 64,
  parameter int unsigned HW_W          = 16,
  parameter int unsigned SP_ALIGN_BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dit_en,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [INS_W-1:0]  ins_word,
  output logic [RIDX_W-1:0] rd_base_idx,
  input  logic [XLEN-1:0]   rd_base_data,
  output logic [RIDX_W-1:0] rd_xfer_idx,
  input  logic [HW_W-1:0]   rd_xfer_data,
  input  logic [XLEN-1:0]   sp_value,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [XLEN-1:0]   req_addr,
  output logic              req_write,
  output logic [HW_W-1:0]   req_wdata,
  output logic [3:0]        req_nbytes,
  output logic              req_tagchk,
  output logic              req_acquire,
  output logic              req_release,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [HW_W-1:0]   rsp_rdata,
  output logic              wb_valid,
  output logic [RIDX_W-1:0] wb_idx,
  output logic [XLEN-1:0]   wb_data,
  output logic              wb_is64,
  output logic              busy,
  output logic              fault_undef,
  output logic              fault_align
);

  localparam logic [RIDX_W-1:0] ZR_IDX       = '1;
  localparam logic [3:0]        ACCESS_BYTES = 4'(HW_W / 8);

  ldst_state_e       st_q;
  logic [INS_W-1:0]  ins_q;
  logic [XLEN-1:0]   base_q;
  logic [HW_W-1:0]   xfer_q;
  logic [XLEN-1:0]   sp_q;
  logic              dit_q;
  logic [XLEN-1:0]   addr_q;
  logic              tag_q;
  logic [HW_W-1:0]   wdata_q;
  logic              write_q;
  logic              acq_q;
  logic [HW_W-1:0]   rdata_q;
  logic              fault_undef_q;
  logic              fault_align_q;

  ldst_dec_t         dec;
  logic [XLEN-1:0]   agen_addr;
  logic              agen_use_sp;
  logic              agen_misaligned;
  logic              agen_tag;
  logic [XLEN-1:0]   ext_value;
  logic              ext_is64;
  logic              has_wb;

  hw_ldst_decode u_decode (
    .ins (ins_q),
    .dec (dec)
  );

  hw_ldst_agen #(
    .AW         (XLEN),
    .OW         (OFF_W),
    .ALIGN_BITS (SP_ALIGN_BITS),
    .IW         (RIDX_W)
  ) u_agen (
    .base_idx      (dec.rn),
    .gpr_base      (base_q),
    .sp_base       (sp_q),
    .off           (dec.off),
    .addr          (agen_addr),
    .use_sp        (agen_use_sp),
    .sp_misaligned (agen_misaligned),
    .tag_check     (agen_tag)
  );

  hw_ldst_extend #(
    .XLEN (XLEN),
    .HW_W (HW_W)
  ) u_extend (
    .raw   (rdata_q),
    .op    (dec.op),
    .value (ext_value),
    .is64  (ext_is64)
  );

  // Register-file read indices follow the presented word
  assign rd_base_idx = ins_word[RN_LSB +: RIDX_W];
  assign rd_xfer_idx = ins_word[RT_LSB +: RIDX_W];

  assign has_wb = op_is_load(dec.op) && (dec.rt != ZR_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q          <= S_IDLE;
      ins_q         <= '0;
      base_q        <= '0;
      xfer_q        <= '0;
      sp_q          <= '0;
      dit_q         <= 1'b0;
      addr_q        <= '0;
      tag_q         <= 1'b0;
      wdata_q       <= '0;
      write_q       <= 1'b0;
      acq_q         <= 1'b0;
      rdata_q       <= '0;
      fault_undef_q <= 1'b0;
      fault_align_q <= 1'b0;
    end else begin
      fault_undef_q <= 1'b0;
      fault_align_q <= 1'b0;
      case (st_q)
        S_IDLE: begin
          if (ins_valid) begin
            ins_q  <= ins_word;
            base_q <= rd_base_data;
            xfer_q <= rd_xfer_data;
            sp_q   <= sp_value;
            dit_q  <= dit_en;
            st_q   <= S_DEC;
          end
        end
        S_DEC: begin
          if (dec.legal) begin
            st_q <= S_AGEN;
          end else begin
            fault_undef_q <= 1'b1;
            st_q          <= S_IDLE;
          end
        end
        S_AGEN: begin
          if (agen_misaligned) begin
            fault_align_q <= 1'b1;
            st_q          <= S_IDLE;
          end else begin
            addr_q  <= agen_addr;
            tag_q   <= agen_tag;
            write_q <= (dec.op == OP_ST);
            acq_q   <= op_is_load(dec.op);
            wdata_q <= (dec.rt == ZR_IDX) ? '0 : xfer_q;
            st_q    <= S_ISSUE;
          end
        end
        S_ISSUE: begin
          if (req_ready) st_q <= S_WAIT;
        end
        S_WAIT: begin
          if (rsp_valid) begin
            rdata_q <= rsp_rdata;
            st_q    <= (dit_q || has_wb) ? S_WB : S_IDLE;
          end
        end
        S_WB: begin
          st_q <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign ins_ready   = (st_q == S_IDLE);
  assign busy        = (st_q != S_IDLE);
  assign req_valid   = (st_q == S_ISSUE);
  assign req_addr    = addr_q;
  assign req_write   = write_q;
  assign req_wdata   = wdata_q;
  assign req_nbytes  = ACCESS_BYTES;
  assign req_tagchk  = tag_q;
  assign req_acquire = acq_q;
  assign req_release = !acq_q;
  assign rsp_ready   = (st_q == S_WAIT);
  assign wb_valid    = (st_q == S_WB) && has_wb;
  assign wb_idx      = dec.rt;
  assign wb_data     = ext_value;
  assign wb_is64     = ext_is64;
  assign fault_undef = fault_undef_q;
  assign fault_align = fault_align_q;

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && ins_ready |=> busy && !ins_ready); // R1

  AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    fault_undef |-> !req_valid && !wb_valid); // R2

  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_is64 |-> wb_data[XLEN-1:XLEN/2] == '0); // R3

  AST_ALIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    fault_align |-> !req_valid && !wb_valid); // R5

  AST_TAG_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_tagchk == (ins_q[RN_LSB +: RIDX_W] != ZR_IDX)); // R6

  AST_ORDER_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_acquire != req_release) && (req_acquire == !req_write)); // R8

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) &&
                                $stable(req_wdata) && $stable(req_write)); // R9

  AST_NO_REQ_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> !req_valid && busy); // R10

  AST_WB_NOT_ZR: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> wb_idx != ZR_IDX && !req_write); // R11

  AST_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fault_undef, fault_align})); // R2

endmodule

// File: tb/hw_ldst_unit_tb.sv
module hw_ldst_unit_tb;

  localparam time CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dit_en = 1'b0;
  logic        ins_valid = 1'b0;
  logic        ins_ready;
  logic [31:0] ins_word = '0;
  logic [4:0]  rd_base_idx;
  logic [63:0] rd_base_data = '0;
  logic [4:0]  rd_xfer_idx;
  logic [15:0] rd_xfer_data = '0;
  logic [63:0] sp_value = '0;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic [63:0] req_addr;
  logic        req_write;
  logic [15:0] req_wdata;
  logic [3:0]  req_nbytes;
  logic        req_tagchk;
  logic        req_acquire;
  logic        req_release;
  logic        rsp_valid = 1'b0;
  logic        rsp_ready;
  logic [15:0] rsp_rdata = '0;
  logic        wb_valid;
  logic [4:0]  wb_idx;
  logic [63:0] wb_data;
  logic        wb_is64;
  logic        busy;
  logic        fault_undef;
  logic        fault_align;

  always #(CLK_PERIOD/2) clk = ~clk;

  hw_ldst_unit u_dut (.*);

  int checks = 0;
  int fails  = 0;

  // Captured observations of the last operation
  int          n_req, n_wb, cycles;
  logic        got_undef, got_align, unstable, early_free;
  logic [63:0] c_addr;
  logic        c_write, c_tag, c_acq, c_rel;
  logic [15:0] c_wdata;
  logic [3:0]  c_nbytes;
  logic [4:0]  c_wb_idx;
  logic [63:0] c_wb_data;
  logic        c_wb64;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input logic [1:0] op, input logic [8:0] off,
                                      input logic [4:0] rn, input logic [4:0] rt);
    return {8'h59, op, 1'b0, off, 2'b00, rn, rt};
  endfunction

  task automatic exec(input logic [31:0] w, input logic [63:0] base, input logic [15:0] xfer,
                      input logic [63:0] sp, input logic [15:0] rdata, input logic dit,
                      input int req_stall, input int rsp_stall);
    int rq = 0;
    int rs = 0;
    n_req = 0; n_wb = 0; cycles = 0;
    got_undef = 0; got_align = 0; unstable = 0; early_free = 0;
    c_addr = '0; c_write = 0; c_tag = 0; c_acq = 0; c_rel = 0; c_wdata = '0; c_nbytes = '0;
    c_wb_idx = '0; c_wb_data = '0; c_wb64 = 0;
    @(negedge clk);
    ins_word = w; rd_base_data = base; rd_xfer_data = xfer; sp_value = sp;
    dit_en = dit; ins_valid = 1'b1;
    @(negedge clk);
    ins_valid = 1'b0;
    cycles = 1;
    while (!ins_ready && cycles < 200) begin
      req_ready = 1'b0;
      rsp_valid = 1'b0;
      if (!busy) early_free = 1;
      if (fault_undef) got_undef = 1;
      if (fault_align) got_align = 1;
      if (wb_valid) begin
        n_wb++; c_wb_idx = wb_idx; c_wb_data = wb_data; c_wb64 = wb_is64;
      end
      if (req_valid) begin
        if (rq == 0) begin
          c_addr = req_addr; c_write = req_write; c_wdata = req_wdata; c_nbytes = req_nbytes;
          c_tag = req_tagchk; c_acq = req_acquire; c_rel = req_release;
        end else if (req_addr !== c_addr || req_wdata !== c_wdata || req_write !== c_write) begin
          unstable = 1;
        end
        if (rq >= req_stall) begin
          req_ready = 1'b1;
          n_req++;
        end
        rq++;
      end
      if (rsp_ready) begin
        if (rs >= rsp_stall) begin
          rsp_valid = 1'b1;
          rsp_rdata = rdata;
        end
        rs++;
      end
      @(negedge clk);
      cycles++;
    end
    req_ready = 1'b0;
    rsp_valid = 1'b0;
    if (fault_undef) got_undef = 1;
    if (fault_align) got_align = 1;
  endtask

  task automatic t_reset();
    check("R1 reset ins_ready", ins_ready, 1);
    check("R1 reset busy", busy, 0);
    check("R10 reset req_valid", req_valid, 0);
    check("R11 reset wb_valid", wb_valid, 0);
    check("R2 reset faults", {fault_undef, fault_align}, 0);
  endtask

  task automatic t_store();
    exec(enc(2'b00, 9'd4, 5'd3, 5'd7), 64'h1000, 16'hABCD, 64'h0, 16'h0, 1'b0, 0, 0);
    check("R4 store addr", c_addr, 64'h1004);
    check("R7 store write", c_write, 1);
    check("R7 store data", c_wdata, 16'hABCD);
    check("R7 store size", c_nbytes, 2);
    check("R6 store tag", c_tag, 1);
    check("R8 store marks", {c_acq, c_rel}, 2'b01);
    check("R11 store no wb", n_wb, 0);
    check("R10 store one req", n_req, 1);
  endtask

  task automatic t_store_zr();
    exec(enc(2'b00, 9'd0, 5'd2, 5'd31), 64'h3000, 16'h5A5A, 64'h0, 16'h0, 1'b0, 0, 0);
    check("R7 zr store data", c_wdata, 16'h0000);
    check("R4 zr store addr", c_addr, 64'h3000);
  endtask

  task automatic t_ld_zext();
    exec(enc(2'b01, 9'h100, 5'd4, 5'd9), 64'h2000, 16'h0, 64'h0, 16'h8001, 1'b0, 0, 0);
    check("R4 neg offset addr", c_addr, 64'h1F00);
    check("R8 load marks", {c_acq, c_rel, c_write}, 3'b100);
    check("R11 ldz wb count", n_wb, 1);
    check("R11 ldz wb idx", c_wb_idx, 9);
    check("R3 ldz value", c_wb_data, 64'h0000_0000_0000_8001);
    check("R3 ldz width", c_wb64, 0);
  endtask

  task automatic t_ld_sext64();
    exec(enc(2'b10, 9'd2, 5'd1, 5'd0), 64'h40, 16'h0, 64'h0, 16'h8001, 1'b0, 0, 0);
    check("R3 lds64 value", c_wb_data, 64'hFFFF_FFFF_FFFF_8001);
    check("R3 lds64 width", c_wb64, 1);
    check("R11 lds64 idx", c_wb_idx, 0);
  endtask

  task automatic t_ld_sext32();
    exec(enc(2'b11, 9'd0, 5'd1, 5'd12), 64'h40, 16'h0, 64'h0, 16'h8001, 1'b0, 0, 0);
    check("R3 lds32 neg value", c_wb_data, 64'h0000_0000_FFFF_8001);
    check("R3 lds32 width", c_wb64, 0);
    exec(enc(2'b11, 9'd0, 5'd1, 5'd12), 64'h40, 16'h0, 64'h0, 16'h7FFF, 1'b0, 0, 0);
    check("R3 lds32 pos value", c_wb_data, 64'h0000_0000_0000_7FFF);
  endtask

  task automatic t_sp_base();
    exec(enc(2'b01, 9'h0FF, 5'd31, 5'd5), 64'hDEAD_BEEF_DEAD_BEEF, 16'h0,
         64'h0000_0000_8000_0010, 16'h1234, 1'b0, 0, 0);
    check("R5 sp base addr", c_addr, 64'h0000_0000_8000_010F);
    check("R6 sp no tag", c_tag, 0);
    check("R5 sp aligned no fault", got_align, 0);
    check("R3 sp load value", c_wb_data, 64'h1234);
  endtask

  task automatic t_sp_misaligned();
    exec(enc(2'b01, 9'd0, 5'd31, 5'd5), 64'h0, 16'h0, 64'h0000_0000_8000_0018, 16'h1, 1'b0, 0, 0);
    check("R5 misaligned fault", got_align, 1);
    check("R5 misaligned no req", n_req, 0);
    check("R5 misaligned no wb", n_wb, 0);
  endtask

  task automatic t_undef();
    logic [31:0] good;
    good = enc(2'b01, 9'd0, 5'd1, 5'd2);
    exec(good | 32'h0020_0000, 64'h0, 16'h0, 64'h0, 16'h0, 1'b0, 0, 0);
    check("R2 bit21 fault", got_undef, 1);
    check("R2 bit21 no req", n_req, 0);
    exec(good | 32'h0000_0400, 64'h0, 16'h0, 64'h0, 16'h0, 1'b0, 0, 0);
    check("R2 gap bits fault", got_undef, 1);
    check("R2 gap bits no wb", n_wb, 0);
    exec({8'h58, good[23:0]}, 64'h0, 16'h0, 64'h0, 16'h0, 1'b0, 0, 0);
    check("R2 top byte fault", got_undef, 1);
    check("R2 top byte no req", n_req, 0);
    exec(good, 64'h0, 16'h0, 64'h0, 16'h0, 1'b0, 0, 0);
    check("R2 legal no fault", got_undef, 0);
  endtask

  task automatic t_backpressure();
    int base_lat;
    exec(enc(2'b10, 9'd8, 5'd6, 5'd3), 64'h500, 16'h0, 64'h0, 16'hFFFE, 1'b1, 0, 0);
    base_lat = cycles;
    exec(enc(2'b10, 9'd8, 5'd6, 5'd3), 64'h500, 16'h0, 64'h0, 16'hFFFE, 1'b1, 3, 4);
    check("R9 stalled req stable", unstable, 0);
    check("R9 stalled addr", c_addr, 64'h508);
    check("R10 stalled one req", n_req, 1);
    check("R10 busy held", early_free, 0);
    check("R10 latency includes stalls", cycles, base_lat + 7);
    check("R3 stalled value", c_wb_data, 64'hFFFF_FFFF_FFFF_FFFE);
  endtask

  task automatic t_load_zr();
    exec(enc(2'b10, 9'd0, 5'd6, 5'd31), 64'h600, 16'h0, 64'h0, 16'h4444, 1'b0, 0, 0);
    check("R11 zr load no wb", n_wb, 0);
    check("R10 zr load still reads", n_req, 1);
  endtask

  task automatic t_dit();
    int l_ld, l_ld0, l_zr, l_st, l_zr_fast, l_st_fast;
    exec(enc(2'b11, 9'd0, 5'd1, 5'd4), 64'h10, 16'h0, 64'h0, 16'hFFFF, 1'b1, 0, 0);
    l_ld = cycles;
    exec(enc(2'b11, 9'd0, 5'd1, 5'd4), 64'h10, 16'h0, 64'h0, 16'h0000, 1'b1, 0, 0);
    l_ld0 = cycles;
    exec(enc(2'b11, 9'd0, 5'd1, 5'd31), 64'h10, 16'h0, 64'h0, 16'hFFFF, 1'b1, 0, 0);
    l_zr = cycles;
    exec(enc(2'b00, 9'd0, 5'd1, 5'd4), 64'h10, 16'h0, 64'h0, 16'h0, 1'b1, 0, 0);
    l_st = cycles;
    exec(enc(2'b11, 9'd0, 5'd1, 5'd31), 64'h10, 16'h0, 64'h0, 16'hFFFF, 1'b0, 0, 0);
    l_zr_fast = cycles;
    exec(enc(2'b00, 9'd0, 5'd1, 5'd4), 64'h10, 16'h0, 64'h0, 16'h0, 1'b0, 0, 0);
    l_st_fast = cycles;
    check("R12 dit data independent", l_ld0, l_ld);
    check("R12 dit zr same", l_zr, l_ld);
    check("R12 dit store same", l_st, l_ld);
    check("R12 no dit zr shorter", l_zr_fast, l_ld - 1);
    check("R12 no dit store shorter", l_st_fast, l_ld - 1);
  endtask

  task automatic t_read_idx();
    @(negedge clk);
    ins_word = enc(2'b00, 9'd0, 5'd17, 5'd22);
    #1;
    check("R4 base read idx", rd_base_idx, 17);
    check("R4 xfer read idx", rd_xfer_idx, 22);
    check("R1 idle ready", ins_ready, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R10 watchdog: actual hung expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_idx();
    t_store();
    t_store_zr();
    t_ld_zext();
    t_ld_sext64();
    t_ld_sext32();
    t_sp_base();
    t_sp_misaligned();
    t_undef();
    t_backpressure();
    t_load_zr();
    t_dit();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule